// File: doc/BRIEF.md
# Pixel Time-Over-Threshold Hit Logic

This block is the digital half of a single pixel cell in a self-triggered hybrid pixel readout chip. A free-running time-stamp is Gray encoded once and sent to every pixel on a shared bus. The cell watches the output of the pixel's discriminator. It stores the time-stamp present when the pulse crosses threshold on the way up, and the time-stamp present when it drops back below threshold. The time between the two is the time over threshold, which serves as the charge measurement. A single hit is held until the column read-out logic collects it.

A small serial configuration register is loaded while a configuration phase is active, with one bit per clock. One of its bits masks the pixel. The other bits go to the analogue trim. Column read commands place the stored leading-edge or trailing-edge word on a shared column bus, which is wired-OR friendly: the cell drives all zeros unless it is being read. A freeze input stops new captures while the column is being read. A hit-clear input drops any pending or half-built hit.

Top module: `pix_tot_cell`

## Requirements
- R1: After `rst_n` is held low, `hit_pending` is 0, `col_oe` is 0, `col_data` is all zeros, and `cfg_word` is all zeros.
- R2: A rising edge of `disc_in` loads the value on `ts_gray` into the leading-edge register. A read with `rd_le` high returns that value on `col_data` in the same cycle, and leaves `hit_pending` unchanged.
- R3: A falling edge of `disc_in` that follows a captured rising edge loads `ts_gray` into the trailing-edge register and sets `hit_pending`. With the default two-stage synchroniser, a level change of `disc_in` is captured on the third rising clock edge after the change.
- R4: A cycle with `rd_te` high drives the trailing-edge word on `col_data` and clears `hit_pending` at the next clock edge.
- R5: When neither read command is high, `col_oe` is 0 and `col_data` is all zeros. When both are high, the leading-edge word is driven.
- R6: While `hit_pending` is 1, new discriminator edges change neither stored word, so a stored hit is never overwritten.
- R7: While `freeze` is high, discriminator edges capture nothing.
- R8: When configuration bit 0 (the mask bit) is 1, discriminator edges capture nothing and `hit_pending` stays 0.
- R9: While `cfg_phase` is high, `cfg_word` shifts left by one bit per clock, taking `cfg_sdi` into bit 0. `cfg_sdo` always equals the top bit of `cfg_word`. Discriminator edges capture nothing during the phase. `cfg_word` holds its value when `cfg_phase` is low.
- R10: `hit_clr` clears `hit_pending` and discards a leading edge that is waiting for its trailing edge. A later falling edge then sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low reset of all state |
| disc_in | input | 1 | Asynchronous discriminator output |
| ts_gray | input | 12 | Shared Gray-coded time-stamp |
| freeze | input | 1 | Blocks new captures during column read-out |
| hit_clr | input | 1 | Clears hit state |
| cfg_phase | input | 1 | Configuration shift enable |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Serial configuration data out (chain) |
| cfg_word | output | 5 | Configuration contents; bit 0 is the mask |
| rd_le | input | 1 | Read leading-edge word |
| rd_te | input | 1 | Read trailing-edge word, acknowledges hit |
| col_data | output | 12 | Column bus contribution, zero when idle |
| col_oe | output | 1 | Cell is driving the column bus |
| hit_pending | output | 1 | A complete hit is stored |

## Verification
The bench targets overwrite protection: a second pulse arrives while a hit is still pending. A cell that lacks the protection reports the newer leading edge and loses the stored hit. It also sends pulses during freeze, while the pixel is masked, and during the configuration phase. A cell that leaks any of these reports a hit that should not exist. A hit-clear between the two edges checks that a half-built hit is dropped and not completed by the later fall. The bench also raises both read commands together, and checks the idle bus for zeros, which would reveal a wrong priority or a cell that pollutes the wired-OR bus.

// File: rtl/pix_tot_pkg.sv
package pix_tot_pkg;

   typedef enum logic [1:0] {
      SEL_IDLE = 2'd0,
      SEL_LEAD = 2'd1,
      SEL_TRAIL = 2'd2
   } bus_sel_e;

   function automatic bus_sel_e pick_sel(input logic want_le, input logic want_te);
      if (want_le)      return SEL_LEAD;
      else if (want_te) return SEL_TRAIL;
      else              return SEL_IDLE;
   endfunction

endpackage

// File: rtl/pix_sync.sv
module pix_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   initial begin
      if (STAGES < 2) $error("pix_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pix_edge_det.sv
module pix_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
endmodule

// File: rtl/pix_hit_ctrl.sv
module pix_hit_ctrl #(
   parameter int TS_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rise,
   input  logic            fall,
   input  logic [TS_W-1:0] ts_gray,
   input  logic            block_cap,
   input  logic            hit_clr,
   input  logic            ack_te,
   output logic [TS_W-1:0] le_q,
   output logic [TS_W-1:0] te_q,
   output logic            pending_q
);
   logic armed_q;
   logic cap_ok;
   logic take_le;
   logic take_te;

   assign cap_ok  = ~block_cap & ~pending_q & ~hit_clr;
   assign take_le = cap_ok & rise;
   assign take_te = cap_ok & fall & armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         le_q <= '0;
         te_q <= '0;
      end else begin
         if (take_le) le_q <= ts_gray;
         if (take_te) te_q <= ts_gray;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         pending_q <= 1'b0;
      end else if (hit_clr) begin
         armed_q   <= 1'b0;
         pending_q <= 1'b0;
      end else begin
         if (take_le)      armed_q <= 1'b1;
         else if (take_te) armed_q <= 1'b0;
         if (take_te)      pending_q <= 1'b1;
         else if (ack_te)  pending_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pix_cfg_sreg.sv
module pix_cfg_sreg #(
   parameter int CFG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             sdi,
   output logic             sdo,
   output logic [CFG_W-1:0] word
);
   initial begin
      if (CFG_W < 1) $error("pix_cfg_sreg: CFG_W must be positive");
   end

   generate
      if (CFG_W == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)        word <= '0;
            else if (shift_en) word <= sdi;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n)        word <= '0;
            else if (shift_en) word <= {word[CFG_W-2:0], sdi};
         end
      end
   endgenerate

   assign sdo = word[CFG_W-1];
endmodule

// File: rtl/pix_rd_mux.sv
module pix_rd_mux
   import pix_tot_pkg::*;
#(
   parameter int TS_W = 12
) (
   input  logic            rd_le,
   input  logic            rd_te,
   input  logic [TS_W-1:0] le_q,
   input  logic [TS_W-1:0] te_q,
   output logic [TS_W-1:0] bus_data,
   output logic            bus_oe
);
   bus_sel_e sel;

   always_comb begin
      sel = pick_sel(rd_le, rd_te);
      unique case (sel)
         SEL_LEAD:  bus_data = le_q;
         SEL_TRAIL: bus_data = te_q;
         default:   bus_data = '0;
      endcase
      bus_oe = (sel != SEL_IDLE);
   end
endmodule

// File: rtl/pix_tot_cell.sv
module pix_tot_cell #(
   parameter int TS_W        = 12,
   parameter int CFG_W       = 5,
   parameter int MASK_BIT    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disc_in,
   input  logic [TS_W-1:0]  ts_gray,
   input  logic             freeze,
   input  logic             hit_clr,
   input  logic             cfg_phase,
   input  logic             cfg_sdi,
   output logic             cfg_sdo,
   output logic [CFG_W-1:0] cfg_word,
   input  logic             rd_le,
   input  logic             rd_te,
   output logic [TS_W-1:0]  col_data,
   output logic             col_oe,
   output logic             hit_pending
);
   initial begin
      if (TS_W < 2)          $error("pix_tot_cell: TS_W too small");
      if (MASK_BIT >= CFG_W) $error("pix_tot_cell: MASK_BIT outside config word");
      if (MASK_BIT < 0)      $error("pix_tot_cell: MASK_BIT negative");
   end

   logic            disc_s;
   logic            rise;
   logic            fall;
   logic            block_cap;
   logic [TS_W-1:0] le_q;
   logic [TS_W-1:0] te_q;

   pix_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(disc_in), .sync_out(disc_s)
   );

   pix_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .level(disc_s), .rise(rise), .fall(fall)
   );

   pix_cfg_sreg #(.CFG_W(CFG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .shift_en(cfg_phase), .sdi(cfg_sdi),
      .sdo(cfg_sdo), .word(cfg_word)
   );

   assign block_cap = freeze | cfg_phase | cfg_word[MASK_BIT];

   pix_hit_ctrl #(.TS_W(TS_W)) u_hit (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .ts_gray(ts_gray),
      .block_cap(block_cap), .hit_clr(hit_clr), .ack_te(rd_te),
      .le_q(le_q), .te_q(te_q), .pending_q(hit_pending)
   );

   pix_rd_mux #(.TS_W(TS_W)) u_rd (
      .rd_le(rd_le), .rd_te(rd_te), .le_q(le_q), .te_q(te_q),
      .bus_data(col_data), .bus_oe(col_oe)
   );
endmodule

// File: rtl/pix_tot_cell_chk.sv
module pix_tot_cell_chk #(
   parameter int TS_W  = 12,
   parameter int CFG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             freeze,
   input logic             hit_clr,
   input logic             cfg_phase,
   input logic [CFG_W-1:0] cfg_word,
   input logic             cfg_sdo,
   input logic             rd_le,
   input logic             rd_te,
   input logic [TS_W-1:0]  col_data,
   input logic             col_oe,
   input logic             hit_pending,
   input logic [TS_W-1:0]  le_q,
   input logic [TS_W-1:0]  te_q
);
   AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_le && !rd_te) |-> (!col_oe && col_data == '0)); // R5
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_pending && rd_te) |=> !hit_pending); // R4
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |=> !hit_pending); // R10
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pending |=> ($stable(le_q) && $stable(te_q))); // R6
   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> ($stable(le_q) && $stable(te_q))); // R7
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_phase |=> $stable(cfg_word)); // R9
   AST_CFG_NOCAP: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_phase |=> $stable(le_q)); // R9
   AST_SDO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sdo == cfg_word[CFG_W-1]); // R9
   AST_LE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_le && rd_te) |-> (col_oe && col_data == le_q)); // R5
endmodule

bind pix_tot_cell pix_tot_cell_chk #(.TS_W(TS_W), .CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .freeze(freeze), .hit_clr(hit_clr),
   .cfg_phase(cfg_phase), .cfg_word(cfg_word), .cfg_sdo(cfg_sdo),
   .rd_le(rd_le), .rd_te(rd_te), .col_data(col_data), .col_oe(col_oe),
   .hit_pending(hit_pending), .le_q(le_q), .te_q(te_q)
);

// File: tb/pix_tot_cell_bench.sv
`timescale 1ns/1ps
module pix_tot_cell_bench;
   localparam int TS_W  = 12;
   localparam int CFG_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             disc_in = 1'b0;
   logic [TS_W-1:0]  ts_gray = '0;
   logic             freeze = 1'b0;
   logic             hit_clr = 1'b0;
   logic             cfg_phase = 1'b0;
   logic             cfg_sdi = 1'b0;
   logic             cfg_sdo;
   logic [CFG_W-1:0] cfg_word;
   logic             rd_le = 1'b0;
   logic             rd_te = 1'b0;
   logic [TS_W-1:0]  col_data;
   logic             col_oe;
   logic             hit_pending;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [TS_W-1:0] exp_q[$];
   string           tag_q[$];

   always #2.5 clk = ~clk;

   pix_tot_cell u_pix_tot_cell (
      .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .ts_gray(ts_gray),
      .freeze(freeze), .hit_clr(hit_clr), .cfg_phase(cfg_phase),
      .cfg_sdi(cfg_sdi), .cfg_sdo(cfg_sdo), .cfg_word(cfg_word),
      .rd_le(rd_le), .rd_te(rd_te), .col_data(col_data), .col_oe(col_oe),
      .hit_pending(hit_pending)
   );

   // Monitor: every bus cycle pops one expected word.
   always @(negedge clk) begin
      if (rst_n && col_oe && !finished) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL bus: unexpected drive actual=%h expected=none", col_data);
         end else begin
            automatic logic [TS_W-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (col_data !== e) begin
               bad++;
               $display("FAIL %s: col_data actual=%h expected=%h", t, col_data, e);
            end
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [TS_W-1:0] t_rise, input logic [TS_W-1:0] t_fall);
      ts_gray = t_rise; disc_in = 1'b1; step(5);
      ts_gray = t_fall; disc_in = 1'b0; step(5);
   endtask

   task automatic read_bus(input bit le, input bit te,
                           input logic [TS_W-1:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_le = le; rd_te = te;
      step(1);
      rd_le = 1'b0; rd_te = 1'b0;
      step(1);
   endtask

   task automatic load_cfg(input logic [CFG_W-1:0] v);
      cfg_phase = 1'b1;
      for (int i = CFG_W - 1; i >= 0; i--) begin
         cfg_sdi = v[i];
         step(1);
      end
      cfg_phase = 1'b0; cfg_sdi = 1'b0;
      step(1);
   endtask

   initial begin
      step(3);
      // R1 reset state
      check("R1 pending", 32'(hit_pending), 32'd0);
      check("R1 oe", 32'(col_oe), 32'd0);
      check("R1 data", 32'(col_data), 32'd0);
      check("R1 cfg", 32'(cfg_word), 32'd0);
      rst_n = 1'b1;
      step(2);

      // R2 R3 R4 basic hit
      pulse(12'h123, 12'h1A5);
      check("R3 pending set", 32'(hit_pending), 32'd1);
      read_bus(1, 0, 12'h123, "R2 leading word");
      check("R2 pending kept after le read", 32'(hit_pending), 32'd1);
      read_bus(0, 1, 12'h1A5, "R4 trailing word");
      check("R4 pending cleared", 32'(hit_pending), 32'd0);
      // R5 idle bus
      check("R5 idle oe", 32'(col_oe), 32'd0);
      check("R5 idle data", 32'(col_data), 32'd0);

      // R6 second pulse while pending
      pulse(12'h0F0, 12'h0F8);
      pulse(12'hABC, 12'hABD);
      read_bus(1, 0, 12'h0F0, "R6 leading kept");
      read_bus(0, 1, 12'h0F8, "R6 trailing kept");

      // R7 freeze
      freeze = 1'b1;
      pulse(12'h555, 12'h556);
      freeze = 1'b0;
      step(1);
      check("R7 no hit under freeze", 32'(hit_pending), 32'd0);
      read_bus(1, 0, 12'h0F0, "R7 leading unchanged");

      // R9 configuration shift and sdo
      load_cfg(5'b10110);
      check("R9 cfg word", 32'(cfg_word), 32'h16);
      check("R9 sdo", 32'(cfg_sdo), 32'd1);
      // R8 mask
      load_cfg(5'b00001);
      check("R8 mask loaded", 32'(cfg_word), 32'h01);
      pulse(12'h777, 12'h778);
      check("R8 masked pending", 32'(hit_pending), 32'd0);
      read_bus(1, 0, 12'h0F0, "R8 leading unchanged");
      load_cfg(5'b00000);

      // R9 pulse during configuration phase
      cfg_phase = 1'b1; cfg_sdi = 1'b0;
      pulse(12'h321, 12'h322);
      cfg_phase = 1'b0;
      step(1);
      check("R9 no hit in cfg phase", 32'(hit_pending), 32'd0);
      check("R9 cfg shifted zeros", 32'(cfg_word), 32'h00);
      read_bus(1, 0, 12'h0F0, "R9 leading unchanged");

      // R10 clear between edges
      ts_gray = 12'h400; disc_in = 1'b1; step(5);
      hit_clr = 1'b1; step(1); hit_clr = 1'b0;
      ts_gray = 12'h401; disc_in = 1'b0; step(5);
      check("R10 half hit dropped", 32'(hit_pending), 32'd0);
      // R10 clear of full hit
      pulse(12'h600, 12'h60F);
      check("R10 hit present", 32'(hit_pending), 32'd1);
      hit_clr = 1'b1; step(1); hit_clr = 1'b0;
      check("R10 pending cleared", 32'(hit_pending), 32'd0);

      // R5 both reads: leading wins
      pulse(12'h9C3, 12'h9E1);
      read_bus(1, 1, 12'h9C3, "R5 priority");
      check("R4 ack with both reads", 32'(hit_pending), 32'd0);
      read_bus(0, 1, 12'h9E1, "R3 trailing stored");

      step(2);
      check("scoreboard drained", 32'(exp_q.size()), 32'd0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule